// File: doc/BRIEF.md
# Multiplexer-Accelerated CORDIC Sine/Cosine

This block computes approximate cosine and sine of a signed angle. It uses a fully unrolled CORDIC in circular rotation mode with six micro-rotations. The vector starts at a hard-wired x coordinate equal to the reciprocal of the six-stage gain, with y at zero. Because of that starting point the final coordinates already have unit scale, and no gain correction follows the last stage.

The first three or four micro-rotations are not built as shifters and adders. Only the residual-angle adders stay in that part, and they produce one direction bit per stage. Those bits index a table of precomputed (x, y) pairs. The tables are computed when the design is elaborated, using the same shift-add arithmetic, so the result is bit-identical to the conventional chain. The remaining stages are ordinary shift-add micro-rotations.

With pipelining enabled, a register follows the table front and each conventional stage. A valid flag travels with the data. With pipelining disabled, the whole path is combinational.

Top module: `cordic_mux_top`

## Requirements
- R1: The outputs equal a bit-accurate six-step shift-add model. The model starts with x = round(0.607352·2^(W-2)) (9951 at W=16), y = 0 and z = angle. At step i (i = 0..5), if the sign bit of z is 0, then x -= y>>>i, y += x>>>i and z -= A_i. If the sign bit is 1, all three signs reverse. The x and y updates use the values from before the step.
- R2: The angle is W-bit two's complement, and code 2^(W-1) stands for 180 degrees. cos_o and sin_o are two's complement with 2^(W-2) representing 1.0.
- R3: The angle constants A_0..A_5 are the 8-bit codes 32, 19, 10, 5, 3 and 1, shifted left by W-8 bits.
- R4: MUX_STAGES (3 or 4) leading steps are realised by selecting a precomputed (x, y) pair with their direction bits. The outputs stay bit-identical to R1.
- R5: For any angle within ±99 degrees, each of cos_o and sin_o lies within 6 % of full scale (2^(W-2)) of the ideal value. Neither magnitude exceeds 1.0625 in output units.
- R6: With PIPE = 1, a result appears exactly 7 - MUX_STAGES cycles after its input (4 at the defaults). The block accepts one new angle every clock. res_valid_o is ang_valid_i delayed by that latency.
- R7: With PIPE = 1, a cycle with res_valid_o low leaves cos_o and sin_o unchanged, whatever ang_i does while ang_valid_i is low.
- R8: While rst_n is low, res_valid_o, cos_o and sin_o are all zero (PIPE = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ang_valid_i | input | 1 | Angle on ang_i is to be processed |
| ang_i | input | W | Signed angle, 2^(W-1) = 180 degrees |
| res_valid_o | output | 1 | cos_o and sin_o carry a new result |
| cos_o | output | W | Approximate cosine, 2^(W-2) = 1.0 |
| sin_o | output | W | Approximate sine, 2^(W-2) = 1.0 |

## Verification
The magnitude bounds and the bound on the final residual angle assume that every valid angle lies inside the convergence range of about ±99 degrees. Outside that range the result is unspecified. Every angle the stimulus applies, including the values placed on ang_i while ang_valid_i is low, stays within ±18022 codes at W=16. Reset is held low across several clock edges before any angle is presented. Stimulus changes only on falling clock edges, so the registered stages never see an input change near the sampling edge.

// File: rtl/cordic_mux_pkg.sv
package cordic_mux_pkg;

   // number of micro-rotations in the unrolled chain
   localparam int CM_STAGES = 6;
   // reciprocal of the six-stage rotation gain
   localparam real CM_INV_GAIN = 0.6073520;

   // 8-bit atan(2^-i) codes (128 = 180 degrees) scaled to width w
   function automatic int cm_angle_code(input int stage, input int w);
      int base;
      case (stage)
         0:       base = 32;
         1:       base = 19;
         2:       base = 10;
         3:       base = 5;
         4:       base = 3;
         default: base = 1;
      endcase
      return base <<< (w - 8);
   endfunction

   // starting x coordinate, rounded to nearest with 2^(w-2) = 1.0
   function automatic int cm_start_x(input int w);
      return $rtoi(CM_INV_GAIN * (2.0 ** (w - 2)) + 0.5);
   endfunction

   // reduce an integer to w-bit two's complement, as the datapath would
   function automatic int cm_wrap(input int v, input int w);
      int m;
      m = v & ((1 << w) - 1);
      if (m >= (1 << (w - 1))) m = m - (1 << w);
      return m;
   endfunction

   // coordinates after m shift-add steps for direction pattern dirs
   // (bit s set = positive rotation at step s)
   function automatic int cm_front_xy(input int dirs, input int m, input int w,
                                      input bit want_y);
      int x, y, nx, ny;
      x = cm_start_x(w);
      y = 0;
      for (int s = 0; s < m; s++) begin
         if (dirs[s]) begin
            nx = x - (y >>> s);
            ny = y + (x >>> s);
         end else begin
            nx = x + (y >>> s);
            ny = y - (x >>> s);
         end
         x = cm_wrap(nx, w);
         y = cm_wrap(ny, w);
      end
      return want_y ? y : x;
   endfunction

endpackage

// File: rtl/cordic_mux_front.sv
module cordic_mux_front
   import cordic_mux_pkg::*;
#(
   parameter int W   = 16,
   parameter int M   = 3,
   parameter bit REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vi,
   input  logic signed [W-1:0] ang,
   output logic                vo,
   output logic signed [W-1:0] xo,
   output logic signed [W-1:0] yo,
   output logic signed [W-1:0] zo
);

   localparam int ENTRIES = 1 << M;

   logic signed [W-1:0] zc [M+1];
   logic        [M-1:0] dirs;
   logic signed [W-1:0] tab_x [ENTRIES];
   logic signed [W-1:0] tab_y [ENTRIES];
   logic signed [W-1:0] xm, ym;

   assign zc[0] = ang;

   // residual-angle chain: one direction decision per collapsed step
   for (genvar s = 0; s < M; s++) begin : g_zstep
      localparam logic signed [W-1:0] ANG_K = W'(cm_angle_code(s, W));
      assign dirs[s]   = ~zc[s][W-1];
      assign zc[s+1]   = dirs[s] ? (zc[s] - ANG_K) : (zc[s] + ANG_K);
   end

   // precomputed coordinate table, one entry per direction pattern
   for (genvar e = 0; e < ENTRIES; e++) begin : g_tab
      assign tab_x[e] = W'(cm_front_xy(e, M, W, 1'b0));
      assign tab_y[e] = W'(cm_front_xy(e, M, W, 1'b1));
   end

   assign xm = tab_x[dirs];
   assign ym = tab_y[dirs];

   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vo <= 1'b0;
            xo <= '0;
            yo <= '0;
            zo <= '0;
         end else begin
            vo <= vi;
            if (vi) begin
               xo <= xm;
               yo <= ym;
               zo <= zc[M];
            end
         end
      end
   end else begin : g_comb
      assign vo = vi;
      assign xo = xm;
      assign yo = ym;
      assign zo = zc[M];
   end

endmodule

// File: rtl/cordic_rot_stage.sv
module cordic_rot_stage
   import cordic_mux_pkg::*;
#(
   parameter int W     = 16,
   parameter int SHIFT = 3,
   parameter bit REG   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                vi,
   input  logic signed [W-1:0] xi,
   input  logic signed [W-1:0] yi,
   input  logic signed [W-1:0] zi,
   output logic                vo,
   output logic signed [W-1:0] xo,
   output logic signed [W-1:0] yo,
   output logic signed [W-1:0] zo
);

   localparam logic signed [W-1:0] ANG_K = W'(cm_angle_code(SHIFT, W));

   logic                pos;
   logic signed [W-1:0] xs, ys, nx, ny, nz;

   assign pos = ~zi[W-1];
   assign xs  = xi >>> SHIFT;
   assign ys  = yi >>> SHIFT;
   assign nx  = pos ? (xi - ys) : (xi + ys);
   assign ny  = pos ? (yi + xs) : (yi - xs);
   assign nz  = pos ? (zi - ANG_K) : (zi + ANG_K);

   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vo <= 1'b0;
            xo <= '0;
            yo <= '0;
            zo <= '0;
         end else begin
            vo <= vi;
            if (vi) begin
               xo <= nx;
               yo <= ny;
               zo <= nz;
            end
         end
      end
   end else begin : g_comb
      assign vo = vi;
      assign xo = nx;
      assign yo = ny;
      assign zo = nz;
   end

endmodule

// File: rtl/cordic_mux_top.sv
module cordic_mux_top
   import cordic_mux_pkg::*;
#(
   parameter int W          = 16,
   parameter int MUX_STAGES = 3,
   parameter bit PIPE       = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ang_valid_i,
   input  logic signed [W-1:0] ang_i,
   output logic                res_valid_o,
   output logic signed [W-1:0] cos_o,
   output logic signed [W-1:0] sin_o
);

   localparam int REST    = CM_STAGES - MUX_STAGES;
   localparam int LATENCY = PIPE ? (REST + 1) : 0;

   if (!(MUX_STAGES == 3 || MUX_STAGES == 4)) begin : g_bad_mux
      $error("cordic_mux_top: MUX_STAGES must be 3 or 4");
   end
   if (W < 8 || W > 24) begin : g_bad_width
      $error("cordic_mux_top: W must lie in 8..24");
   end

   logic                vc [REST+1];
   logic signed [W-1:0] xc [REST+1];
   logic signed [W-1:0] yc [REST+1];
   logic signed [W-1:0] zc [REST+1];
   logic signed [W-1:0] resid_fin;

   cordic_mux_front #(
      .W   (W),
      .M   (MUX_STAGES),
      .REG (PIPE)
   ) u_front (
      .clk   (clk),
      .rst_n (rst_n),
      .vi    (ang_valid_i),
      .ang   (ang_i),
      .vo    (vc[0]),
      .xo    (xc[0]),
      .yo    (yc[0]),
      .zo    (zc[0])
   );

   for (genvar k = 0; k < REST; k++) begin : g_stage
      cordic_rot_stage #(
         .W     (W),
         .SHIFT (MUX_STAGES + k),
         .REG   (PIPE)
      ) u_rot (
         .clk   (clk),
         .rst_n (rst_n),
         .vi    (vc[k]),
         .xi    (xc[k]),
         .yi    (yc[k]),
         .zi    (zc[k]),
         .vo    (vc[k+1]),
         .xo    (xc[k+1]),
         .yo    (yc[k+1]),
         .zo    (zc[k+1])
      );
   end

   assign res_valid_o = vc[REST];
   assign cos_o       = xc[REST];
   assign sin_o       = yc[REST];
   assign resid_fin   = zc[REST];

endmodule

// File: rtl/cordic_mux_chk.sv
module cordic_mux_chk #(
   parameter int W    = 16,
   parameter int LAT  = 4,
   parameter bit PIPE = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                out_valid,
   input logic signed [W-1:0] cos_v,
   input logic signed [W-1:0] sin_v,
   input logic signed [W-1:0] z_fin
);

   localparam int UNIT  = 1 << (W - 2);
   localparam int MAG   = UNIT + (UNIT >>> 4);
   localparam int ZLIM  = 2 << (W - 8);

   // R5: magnitudes stay near the unit circle
   p_cos_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (cos_v <= MAG && cos_v >= -MAG));
   p_sin_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sin_v <= MAG && sin_v >= -MAG));
   // R5: residual angle has converged to within two of the smallest step
   p_residual_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (z_fin <= ZLIM && z_fin >= -ZLIM));

   if (PIPE) begin : g_pipe
      logic [LAT-1:0] vq;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vq <= '0;
         else        vq <= {vq[LAT-2:0], in_valid};
      end

      // R6: valid emerges exactly LAT cycles after it entered
      p_valid_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid == vq[LAT-1]);

      // R7: an idle output cycle keeps the previous result
      p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid |-> ($stable(cos_v) && $stable(sin_v)));

      // R8: reset clears the result
      always @(negedge clk) begin
         if (!rst_n) begin
            p_reset_quiet_r8: assert (!out_valid && cos_v == '0 && sin_v == '0);
         end
      end
   end

endmodule

bind cordic_mux_top cordic_mux_chk #(
   .W    (W),
   .LAT  (LATENCY),
   .PIPE (PIPE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (ang_valid_i),
   .out_valid (res_valid_o),
   .cos_v     (cos_o),
   .sin_v     (sin_o),
   .z_fin     (resid_fin)
);

// File: tb/tb_cordic_mux_top.sv
`timescale 1ns/1ps
module tb_cordic_mux_top;

   localparam int W    = 16;
   localparam int M    = 3;
   localparam bit PIPE = 1'b1;
   localparam int LAT  = PIPE ? (7 - M) : 0;
   localparam int UNIT = 1 << (W - 2);

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                ang_valid_i = 1'b0;
   logic signed [W-1:0] ang_i = '0;
   logic                res_valid_o;
   logic signed [W-1:0] cos_o, sin_o;

   int checks = 0;
   int errors = 0;
   int vec [0:127];
   bit done = 1'b0;

   always #2 clk = ~clk;

   cordic_mux_top #(.W(W), .MUX_STAGES(M), .PIPE(PIPE)) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .ang_valid_i (ang_valid_i),
      .ang_i       (ang_i),
      .res_valid_o (res_valid_o),
      .cos_o       (cos_o),
      .sin_o       (sin_o)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_near(input string req, input int act, input real ideal, input real tol);
      real d;
      checks++;
      d = real'(act) - ideal;
      if (d < 0.0) d = -d;
      if (d > tol) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0f (tol %0f)", req, act, ideal, tol);
      end
   endtask

   // independent shift-add model: R1 start value, R3 constants
   function automatic void ref_model(input int ang, output int rx, output int ry);
      int x, y, z, nx, ny;
      int a8 [6] = '{32, 19, 10, 5, 3, 1};
      x = 9951; y = 0; z = ang;
      for (int i = 0; i < 6; i++) begin
         if (z >= 0) begin
            nx = x - (y >>> i); ny = y + (x >>> i); z = z - (a8[i] <<< (W - 8));
         end else begin
            nx = x + (y >>> i); ny = y - (x >>> i); z = z + (a8[i] <<< (W - 8));
         end
         x = nx; y = ny;
      end
      rx = x; ry = y;
   endfunction

   task automatic check_result(input int ang);
      int rx, ry;
      real th;
      ref_model(ang, rx, ry);
      th = real'(ang) * 3.14159265358979 / real'(1 << (W - 1));
      check("R6 valid with result", int'(res_valid_o), 1);
      check("R1/R3/R4 cos bit-exact", int'(cos_o), rx);
      check("R1/R3/R4 sin bit-exact", int'(sin_o), ry);
      check_near("R2/R5 cos accuracy", int'(cos_o), $cos(th) * UNIT, 0.06 * UNIT);
      check_near("R2/R5 sin accuracy", int'(sin_o), $sin(th) * UNIT, 0.06 * UNIT);
   endtask

   // back-to-back stream of n angles from vec, one per clock (R6 throughput)
   task automatic run_stream(input int n);
      for (int k = 0; k < n + LAT; k++) begin
         @(negedge clk);
         if (LAT > 0 && k >= LAT) check_result(vec[k - LAT]);
         if (k < n) begin
            ang_valid_i = 1'b1;
            ang_i = W'(vec[k]);
         end else begin
            ang_valid_i = 1'b0;
            ang_i = '0;
         end
         if (LAT == 0 && k < n) begin
            #1;
            check_result(vec[k]);
         end
      end
      @(negedge clk);
      ang_valid_i = 1'b0;
   endtask

   task automatic t_reset;
      // R8: quiet outputs while reset is held
      check("R8 valid in reset", int'(res_valid_o), 0);
      check("R8 cos in reset", int'(cos_o), 0);
      check("R8 sin in reset", int'(sin_o), 0);
   endtask

   task automatic t_cardinal;
      int list [9] = '{0, 16384, -16384, 8192, -8192, 1, -1, 18000, -18000};
      for (int i = 0; i < 9; i++) vec[i] = list[i];
      run_stream(9);
   endtask

   task automatic t_sweep;
      int n = 0;
      for (int a = -17920; a <= 17920; a += 512) begin
         vec[n] = a;
         n++;
      end
      run_stream(n);
   endtask

   task automatic t_latency;
      int seen = -1;
      int rx, ry;
      @(negedge clk);
      ang_valid_i = 1'b1;
      ang_i = 16'sd4096;
      @(negedge clk);
      ang_valid_i = 1'b0;
      ang_i = -16'sd3000;
      if (res_valid_o && seen < 0) seen = 1;
      for (int c = 2; c <= 10; c++) begin
         @(negedge clk);
         if (res_valid_o && seen < 0) begin
            seen = c;
            ref_model(4096, rx, ry);
            check("R6 latency result cos", int'(cos_o), rx);
         end
      end
      check("R6 latency cycles", seen, LAT);
   endtask

   task automatic t_hold;
      int c0, s0;
      vec[0] = 12000;
      run_stream(1);
      c0 = int'(cos_o);
      s0 = int'(sin_o);
      for (int c = 0; c < 6; c++) begin
         ang_valid_i = 1'b0;
         ang_i = W'(-15000 + c * 4000);
         @(negedge clk);
      end
      check("R7 valid idle", int'(res_valid_o), 0);
      check("R7 cos held", int'(cos_o), c0);
      check("R7 sin held", int'(sin_o), s0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_cardinal();
      t_sweep();
      t_latency();
      t_hold();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule